// File: doc/BRIEF.md
# Double-Edge Video Output Pin Multiplexer

The block sits between a 30-bit internal pixel word and the video output pins of a chip. It runs from a clock at twice the pixel rate. It divides that clock by two to produce a 50/50 duty-cycle pixel clock, which it drives out, and it registers the output pins on the same edges. In the plain single-rate mapping, each output pin carries the pixel bit of the same index for the whole pixel period.

Two packing options let an encoder that samples on both edges of the pixel clock receive a whole pixel per clock over fewer pins:

- **24-bit packing.** A 24-bit colour pixel travels over a 12-pin window. The pixel is laid out as R = bits [29:22], G = bits [19:16] then [15:12], and B = bits [9:2]. During the high half of the clock the window carries the low G nibble and B. During the low half it carries R and the high G nibble.
- **16-bit packing.** A luma/chroma pixel travels over an 8-pin window. The chroma byte is pixel bits [19:12] and the luma byte is pixel bits [9:2]. The chroma byte goes out in the high half and the luma byte in the low half.

Pins outside the active window keep the single-rate mapping.

A 7-bit control register selects the packing. Bits [2:0] hold a format code, bit 5 enables the 16-bit packing, and bit 6 enables the 24-bit packing. Bits [4:3] are reserved.

Top module: `ddr_vout_mux`

## Requirements
- R1: While rst_n is low, vclk_o, every bit of pins_o and every bit of cfg_rdata are 0.
- R2: After reset, vclk_o inverts on every rising edge of clk, so it has half the clk rate and a 50/50 duty cycle. The first edge after reset drives it high.
- R3: pix_i is captured on the clk edge where vclk_o goes high. The captured word alone determines pins_o during both halves of that pixel period, and pix_i has no effect during the low half.
- R4: When cfg bits [2:0] = 3'b100 and cfg bit 6 = 1, and vclk_o is high, pins_o[16:5] = {pixel[15:12], pixel[9:2]}.
- R5: Under the same setting as R4, when vclk_o is low, pins_o[16:5] = {pixel[29:22], pixel[19:16]}.
- R6: When cfg bits [2:0] = 3'b010 and cfg bit 5 = 1 (and the R4 setting does not apply), pins_o[20:13] = pixel[19:12] while vclk_o is high and pixel[9:2] while vclk_o is low.
- R7: Every pin outside the active window equals the pixel bit of the same index during both halves.
- R8: When a format code has no matching enable bit, when an enable bit has no matching format code, or when the code matches neither packing (for example 3'b111 with both enables set), all 30 pins equal the captured pixel bits in both halves.
- R9: A write stores cfg_wdata into the register with bits [4:3] forced to 0. cfg_rdata returns the stored value from the edge after the write, and bits [4:3] always read 0.
- R10: A configuration written on one clk edge governs the pins driven on the next clk edge and on every edge after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_i | input | 30 | Internal pixel word |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 7 | Control register write data |
| cfg_rdata | output | 7 | Control register contents |
| vclk_o | output | 1 | Divided pixel clock driven off chip |
| pins_o | output | 30 | Registered video output pins |

## Verification
The bench targets the half-period boundary. A design that captures the pixel on the wrong edge, or that reads pix_i live during the low half, shows a new pixel's bytes mixed with the old one. It also swaps the two slices of each packing: a design that inverts the phase sense or orders the G nibbles wrongly puts the high-half data on the pins during the low half. It probes mismatched mode/enable combinations and an unmatched format code with both enables set, where a loose decode would pack bits that should pass straight through. It writes ones into the reserved bits and checks the first edge after each write, which catches a register that keeps reserved data or applies a new setting one edge late.

// File: rtl/ddr_vout_pkg.sv
package ddr_vout_pkg;
    localparam int PIX_W  = 30;
    localparam int CFG_W  = 7;
    localparam int FMT_W  = 3;

    localparam logic [FMT_W-1:0] FMT_RGB24 = 3'b100;
    localparam logic [FMT_W-1:0] FMT_YUV16 = 3'b010;

    localparam int EN16_BIT = 5;
    localparam int EN24_BIT = 6;

    // reserved bits [4:3] are cleared on every write
    localparam logic [CFG_W-1:0] CFG_KEEP = 7'b110_0111;

    // window bounds
    localparam int W24_LO = 5;
    localparam int W24_HI = 16;
    localparam int W16_LO = 13;
    localparam int W16_HI = 20;

    typedef struct packed {
        logic             en24;
        logic             en16;
        logic [FMT_W-1:0] fmt;
    } cfg_fields_t;

    typedef struct packed {
        logic             vclk;
        logic [PIX_W-1:0] pix;
        logic [PIX_W-1:0] pins;
    } out_state_t;
endpackage

// File: rtl/ddr_vout_cfg.sv
module ddr_vout_cfg
    import ddr_vout_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] rdata,
    output cfg_fields_t      fields
);
    logic [CFG_W-1:0] reg_d, reg_q;

    always_comb begin
        reg_d = reg_q;
        if (we) begin
            reg_d = wdata & CFG_KEEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign rdata       = reg_q;
    assign fields.en24 = reg_q[EN24_BIT];
    assign fields.en16 = reg_q[EN16_BIT];
    assign fields.fmt  = reg_q[FMT_W-1:0];
endmodule

// File: rtl/ddr_vout_packer.sv
module ddr_vout_packer
    import ddr_vout_pkg::*;
(
    input  logic [PIX_W-1:0] pix,
    input  logic             phase_hi,
    input  cfg_fields_t      cfg,
    output logic [PIX_W-1:0] pins
);
    localparam int N24 = W24_HI - W24_LO + 1;
    localparam int N16 = W16_HI - W16_LO + 1;

    logic          sel24, sel16;
    logic [N24-1:0] win24;
    logic [N16-1:0] win16;

    always_comb begin
        sel24 = cfg.en24 && (cfg.fmt == FMT_RGB24);
        sel16 = !sel24 && cfg.en16 && (cfg.fmt == FMT_YUV16);
        win24 = phase_hi ? {pix[15:12], pix[9:2]} : {pix[29:22], pix[19:16]};
        win16 = phase_hi ? pix[19:12] : pix[9:2];
    end

    for (genvar i = 0; i < PIX_W; i++) begin : g_pin
        if (i >= W24_LO && i <= W24_HI && i >= W16_LO && i <= W16_HI) begin : g_both
            assign pins[i] = sel24 ? win24[i-W24_LO] : (sel16 ? win16[i-W16_LO] : pix[i]);
        end else if (i >= W24_LO && i <= W24_HI) begin : g_w24
            assign pins[i] = sel24 ? win24[i-W24_LO] : pix[i];
        end else if (i >= W16_LO && i <= W16_HI) begin : g_w16
            assign pins[i] = sel16 ? win16[i-W16_LO] : pix[i];
        end else begin : g_pass
            assign pins[i] = pix[i];
        end
    end
endmodule

// File: rtl/ddr_vout_mux.sv
module ddr_vout_mux
    import ddr_vout_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] pix_i,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    output logic             vclk_o,
    output logic [PIX_W-1:0] pins_o
);
    out_state_t       st_d, st_q;
    cfg_fields_t      cfg;
    logic [PIX_W-1:0] pix_src;
    logic [PIX_W-1:0] packed_pins;

    ddr_vout_cfg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .wdata  (cfg_wdata),
        .rdata  (cfg_rdata),
        .fields (cfg)
    );

    // new pixel enters at the start of the high half, held through the low half
    assign pix_src = st_q.vclk ? st_q.pix : pix_i;

    ddr_vout_packer u_pack (
        .pix      (pix_src),
        .phase_hi (!st_q.vclk),
        .cfg      (cfg),
        .pins     (packed_pins)
    );

    always_comb begin
        st_d      = st_q;
        st_d.vclk = !st_q.vclk;
        if (!st_q.vclk) begin
            st_d.pix = pix_i;
        end
        st_d.pins = packed_pins;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vclk_o = st_q.vclk;
    assign pins_o = st_q.pins;
endmodule

// File: rtl/ddr_vout_chk.sv
module ddr_vout_chk
    import ddr_vout_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [CFG_W-1:0] cfg_wdata,
    input logic [CFG_W-1:0] cfg_rdata,
    input logic             vclk_o,
    input logic [PIX_W-1:0] pins_o
);
    assert_vclk_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (vclk_o != $past(vclk_o)));

    assert_rsvd_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[4:3] == 2'b00);

    assert_cfg_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_rdata == ($past(cfg_wdata) & CFG_KEEP)));

    // pins outside every window stay put across the two halves of a pixel
    assert_outside_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !vclk_o) |->
        (pins_o[29:21] == $past(pins_o[29:21]) && pins_o[4:0] == $past(pins_o[4:0])));

    // with both enables clear the whole pin word holds for the pixel period
    assert_single_rate_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !vclk_o && $past(cfg_rdata[6:5]) == 2'b00
         && $past(cfg_rdata[6:5], 2) == 2'b00) |->
        (pins_o == $past(pins_o)));
endmodule

bind ddr_vout_mux ddr_vout_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .vclk_o    (vclk_o),
    .pins_o    (pins_o)
);

// File: tb/tb_ddr_vout_mux.sv
module tb_ddr_vout_mux;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [29:0] pix_i = '0;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_wdata = '0;
    logic [6:0]  cfg_rdata;
    logic        vclk_o;
    logic [29:0] pins_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    bit          m_phase = 0;
    logic [29:0] m_pix = '0;
    logic [6:0]  m_cfg = '0;
    logic [29:0] m_pins = '0;
    string       m_tag = "R8";

    ddr_vout_mux dut (
        .clk(clk), .rst_n(rst_n), .pix_i(pix_i), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .vclk_o(vclk_o), .pins_o(pins_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // colour-level view of the pixel word
    function automatic logic [29:0] expect_pins(input logic [29:0] p, input bit hi, input logic [6:0] c, output string tag);
        logic [7:0] r, g, b, uv, y;
        logic [29:0] o;
        r = p[29:22]; g = {p[19:16], p[15:12]}; b = p[9:2];
        uv = p[19:12]; y = p[9:2];
        o = p;
        if (c[6] && c[2:0] == 3'b100) begin
            if (hi) begin o[16:5] = {g[3:0], b}; tag = "R4"; end
            else    begin o[16:5] = {r, g[7:4]}; tag = "R5"; end
        end else if (c[5] && c[2:0] == 3'b010) begin
            o[20:13] = hi ? uv : y;
            tag = "R6";
        end else begin
            tag = "R8";
        end
        return o;
    endfunction

    task automatic tick(input logic [29:0] pix, input bit we, input logic [6:0] wd, input bit after_wr);
        string t;
        pix_i = pix; cfg_we = we; cfg_wdata = wd;
        @(posedge clk);
        if (!m_phase) m_pix = pix;
        m_phase = !m_phase;
        m_pins = expect_pins(m_pix, m_phase, m_cfg, t);
        if (we) m_cfg = wd & 7'b1100111;
        @(negedge clk);
        if (after_wr) t = {t, " R10"};
        check("R2", "vclk", {31'd0, vclk_o}, {31'd0, m_phase});
        check("R9", "cfg_rdata", {25'd0, cfg_rdata}, {25'd0, m_cfg});
        check(t, "window[20:5]", {16'd0, pins_o[20:5]}, {16'd0, m_pins[20:5]});
        check("R3 R7", "outside", {18'd0, pins_o[29:21], pins_o[4:0]}, {18'd0, m_pins[29:21], m_pins[4:0]});
    endtask

    task automatic set_cfg(input logic [6:0] v);
        tick($urandom(), 1'b1, v, 1'b0);
        tick($urandom(), 1'b0, '0, 1'b1);
    endtask

    task automatic run_rand(input int n);
        for (int k = 0; k < n; k++) tick({$urandom()}[29:0], 1'b0, '0, 1'b0);
    endtask

    task automatic run_walk();
        for (int k = 0; k < 30; k++) begin
            tick(30'd1 << k, 1'b0, '0, 1'b0);
            tick(~(30'd1 << k), 1'b0, '0, 1'b0);   // low half: must be ignored (R3)
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "vclk in reset", {31'd0, vclk_o}, 32'd0);
        check("R1", "pins in reset", {2'd0, pins_o}, 32'd0);
        check("R1", "cfg in reset", {25'd0, cfg_rdata}, 32'd0);
        rst_n = 1'b1;

        run_rand(8);                              // single-rate
        set_cfg(7'h44); run_rand(16); run_walk(); // 24-bit packing
        tick(30'h3FFF_FFFF, 0, '0, 0); tick(30'h0, 0, '0, 0);
        tick(30'h2AAA_AAAA, 0, '0, 0); tick(30'h1555_5555, 0, '0, 0);
        set_cfg(7'h22); run_rand(16); run_walk(); // 16-bit packing
        set_cfg(7'h24); run_rand(8);              // enable without matching code
        set_cfg(7'h42); run_rand(8);
        set_cfg(7'h04); run_rand(8);              // code without enable
        set_cfg(7'h67); run_rand(8);              // both enables, code 111
        set_cfg(7'h7F); run_rand(8);              // reserved bits written as ones
        set_cfg(7'h64); run_rand(8);              // both enables, code 100
        set_cfg(7'h3A); run_rand(8);              // 16-bit with reserved ones
        set_cfg(7'h00); run_rand(8);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule